// File: doc/BRIEF.md
# Per-core local interrupt router

This block gathers the interrupt sources local to each core of a four-core cluster and turns them into one IRQ level per core. There are four sources per core: its four generic timer lines, its four mailbox levels, a shared GPU line and its own performance monitor line. Software sets which timer lines a core accepts through a per-core enable register. It sets which cores accept their performance monitor interrupt through a routing word, and it changes that word only through separate set and clear addresses. This lets two cores change their own routing bit without a read-modify-write race.

For each core a read-only pending word reports the sources that are currently active and enabled. Bit positions in that word give the service priority, because software handles the lowest set bit first. Register access uses a plain 32-bit bus with word addresses and registered read data.

Top module: `lirq_router`

## Requirements
- R1: After reset every enable and routing bit is zero, `bus_rdata` is zero and every `core_irq` output is low.
- R2: A write to word address N (0 to 3) loads bits 3:0 of the data into core N's timer enable register. The other data bits are dropped, and a read of that address returns the stored 4 bits with bits 31:4 zero.
- R3: Pending bit k (0 to 3) of core N is 1 exactly when timer line k of core N is high and enable bit k of core N is set. Timer k is line `tmr_irq[4*N+k]`, in the order secure physical, non-secure physical, hypervisor physical, virtual.
- R4: A write to word address 4 sets routing bit N for every data bit N (0 to 3) that is 1, and leaves routing bits whose data bit is 0 unchanged.
- R5: A write to word address 5 clears routing bit N for every data bit N that is 1, and leaves the others unchanged. Reads of address 4 or 5 return the routing word in bits 3:0. The routing word changes only through these two addresses.
- R6: Pending bits 7:4 of core N mirror the mailbox levels `mbox_irq[4*N+3:4*N]`, mailbox 0 at bit 4.
- R7: Pending bit 8 (GPU) follows `gpu_irq` for core 0 only and reads 0 for cores 1 to 3.
- R8: Pending bit 9 of core N is 1 exactly when `pmu_irq[N]` is high and routing bit N is set.
- R9: A read of word address 8+N returns core N's pending word with bits 31:10 zero. The read has no side effect, so back-to-back reads return the same value.
- R10: `core_irq[N]` is the OR of core N's pending bits. It follows the inputs combinationally, with no register in the path.
- R11: `bus_rdata` takes its new value on the clock edge where `bus_rd` is sampled high and holds it while `bus_rd` is low. A read of an unmapped word address (6, 7, 12 to 15) returns zero.
- R12: Writes to the pending addresses (8 to 11) and to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tmr_irq | input | 16 | Timer lines, 4 per core |
| mbox_irq | input | 16 | Mailbox levels, 4 per core |
| gpu_irq | input | 1 | Shared GPU interrupt |
| pmu_irq | input | 4 | Performance monitor line per core |
| core_irq | output | 4 | IRQ level per core |

## Verification
The hardest case to reach from the ports is a single routing bit changing while its neighbours keep their state across set and clear writes. The stimulus gets there by first building a mixed routing word. It then writes set and clear data that overlap bits already in the target state and bits that are not. While that happens, every core's performance monitor line is held high, so each routing bit shows up as a distinct pending bit and IRQ level. Masked timer lines get the same treatment: all timer lines are driven high against a sparse enable pattern, so one wrongly passed line is seen at once.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
    localparam int N_CORES = 4;
    localparam int N_TMR   = 4;
    localparam int N_MBOX  = 4;
    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 4;

    localparam int TMR_LSB  = 0;
    localparam int MBOX_LSB = TMR_LSB + N_TMR;
    localparam int GPU_BIT  = MBOX_LSB + N_MBOX;
    localparam int PMU_BIT  = GPU_BIT + 1;
    localparam int PEND_W   = PMU_BIT + 1;

    localparam int A_TEN_BASE  = 0;
    localparam int A_ROUTE_SET = A_TEN_BASE + N_CORES;
    localparam int A_ROUTE_CLR = A_ROUTE_SET + 1;
    localparam int A_PEND_BASE = 8;

    typedef struct packed {
        logic [N_CORES-1:0][N_TMR-1:0] ten;
        logic [N_CORES-1:0]            route;
        logic [BUS_W-1:0]              rdata;
    } lirq_state_t;
endpackage

// File: rtl/lirq_pend.sv
module lirq_pend
    import lirq_pkg::*;
#(
    parameter bit GPU_HERE = 1'b0
) (
    input  logic [N_TMR-1:0]  tmr_i,
    input  logic [N_TMR-1:0]  ten_i,
    input  logic [N_MBOX-1:0] mbox_i,
    input  logic              gpu_i,
    input  logic              pmu_i,
    input  logic              route_i,
    output logic [PEND_W-1:0] pend_o,
    output logic              irq_o
);
    logic gpu_bit;

    generate
        if (GPU_HERE) begin : g_gpu
            assign gpu_bit = gpu_i;
        end else begin : g_nogpu
            assign gpu_bit = 1'b0;
        end
    endgenerate

    always_comb begin
        pend_o                        = '0;
        pend_o[TMR_LSB +: N_TMR]      = tmr_i & ten_i;
        pend_o[MBOX_LSB +: N_MBOX]    = mbox_i;
        pend_o[GPU_BIT]               = gpu_bit;
        pend_o[PMU_BIT]               = pmu_i & route_i;
        irq_o                         = |pend_o;
    end
endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
    import lirq_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic                           re_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [BUS_W-1:0]               wdata_i,
    input  logic [N_CORES-1:0][PEND_W-1:0] pend_i,
    output logic [N_CORES-1:0][N_TMR-1:0]  ten_o,
    output logic [N_CORES-1:0]             route_o,
    output logic [BUS_W-1:0]               rdata_o
);
    lirq_state_t st_d, st_q;

    logic hit_set, hit_clr;
    assign hit_set = (addr_i == ADDR_W'(A_ROUTE_SET));
    assign hit_clr = (addr_i == ADDR_W'(A_ROUTE_CLR));

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            for (int c = 0; c < N_CORES; c++) begin
                if (addr_i == ADDR_W'(A_TEN_BASE + c)) begin
                    st_d.ten[c] = wdata_i[N_TMR-1:0];
                end
            end
            if (hit_set) begin
                st_d.route = st_q.route | wdata_i[N_CORES-1:0];
            end
            if (hit_clr) begin
                st_d.route = st_q.route & ~wdata_i[N_CORES-1:0];
            end
        end
        if (re_i) begin
            st_d.rdata = '0;
            for (int c = 0; c < N_CORES; c++) begin
                if (addr_i == ADDR_W'(A_TEN_BASE + c)) begin
                    st_d.rdata[N_TMR-1:0] = st_q.ten[c];
                end
                if (addr_i == ADDR_W'(A_PEND_BASE + c)) begin
                    st_d.rdata[PEND_W-1:0] = pend_i[c];
                end
            end
            if (hit_set || hit_clr) begin
                st_d.rdata[N_CORES-1:0] = st_q.route;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ten_o   = st_q.ten;
    assign route_o = st_q.route;
    assign rdata_o = st_q.rdata;

    p_route_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && hit_set) |=>
        ((route_o & $past(wdata_i[N_CORES-1:0])) == $past(wdata_i[N_CORES-1:0])));

    p_route_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && hit_clr) |=> ((route_o & $past(wdata_i[N_CORES-1:0])) == '0));

    p_route_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && (hit_set || hit_clr)) |=> $stable(route_o));

    p_ten_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && (addr_i < ADDR_W'(A_TEN_BASE + N_CORES))) |=> $stable(ten_o));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/lirq_router.sv
module lirq_router
    import lirq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [BUS_W-1:0]          bus_wdata,
    output logic [BUS_W-1:0]          bus_rdata,
    input  logic [N_CORES*N_TMR-1:0]  tmr_irq,
    input  logic [N_CORES*N_MBOX-1:0] mbox_irq,
    input  logic                      gpu_irq,
    input  logic [N_CORES-1:0]        pmu_irq,
    output logic [N_CORES-1:0]        core_irq
);
    logic [N_CORES-1:0][N_TMR-1:0]  ten;
    logic [N_CORES-1:0]             route;
    logic [N_CORES-1:0][PEND_W-1:0] pend;

    lirq_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_wr),
        .re_i    (bus_rd),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .pend_i  (pend),
        .ten_o   (ten),
        .route_o (route),
        .rdata_o (bus_rdata)
    );

    generate
        for (genvar c = 0; c < N_CORES; c++) begin : g_core
            lirq_pend #(.GPU_HERE(c == 0)) u_pend (
                .tmr_i   (tmr_irq[c*N_TMR +: N_TMR]),
                .ten_i   (ten[c]),
                .mbox_i  (mbox_irq[c*N_MBOX +: N_MBOX]),
                .gpu_i   (gpu_irq),
                .pmu_i   (pmu_irq[c]),
                .route_i (route[c]),
                .pend_o  (pend[c]),
                .irq_o   (core_irq[c])
            );
        end
    endgenerate

    p_gpu_core0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gpu_irq |-> core_irq[0]);

    p_rdata_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:PEND_W] == '0);

    p_mbox_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_irq[N_MBOX-1:0] != '0) |-> core_irq[0]);
endmodule

// File: tb/lirq_router_tb_top.sv
module lirq_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] tmr_irq = '0;
    logic [15:0] mbox_irq = '0;
    logic        gpu_irq = 1'b0;
    logic [3:0]  pmu_irq = '0;
    logic [3:0]  core_irq;

    always #2.5 clk = ~clk;

    lirq_router dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_irq(tmr_irq), .mbox_irq(mbox_irq), .gpu_irq(gpu_irq),
        .pmu_irq(pmu_irq), .core_irq(core_irq)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [3:0] m_ten [4];
    logic [3:0] m_route;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    function automatic logic [31:0] pend_of(int c);
        logic [31:0] p;
        p = '0;
        p[3:0] = tmr_irq[c*4 +: 4] & m_ten[c];
        p[7:4] = mbox_irq[c*4 +: 4];
        p[8]   = (c == 0) ? gpu_irq : 1'b0;
        p[9]   = pmu_irq[c] & m_route[c];
        return p;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a < 4) m_ten[a] = d[3:0];
        else if (a == 4) m_route = m_route | d[3:0];
        else if (a == 5) m_route = m_route & ~d[3:0];
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_pend(int c, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'(8 + c);
        exp_q.push_back(pend_of(c));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_irq(string tag);
        logic [3:0] e;
        #1;
        for (int c = 0; c < 4; c++) e[c] = |pend_of(c);
        check(tag, {28'd0, core_irq}, {28'd0, e});
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, bus_rdata, e);
        end
    end

    initial begin : watchdog
        #500000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) m_ten[c] = '0;
        m_route = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", bus_rdata, 32'd0);
        check("R1 irq", {28'd0, core_irq}, 32'd0);
        for (int a = 0; a < 16; a++) rd(4'(a), 32'd0, "R1 reset read");

        // R2: enable write and readback, upper bits dropped
        wr(4'd0, 32'hFFFF_FFF5);
        wr(4'd1, 32'h0000_000A);
        wr(4'd2, 32'h0000_0003);
        wr(4'd3, 32'h0000_000C);
        rd(4'd0, 32'h5, "R2 core0 enable");
        rd(4'd1, 32'hA, "R2 core1 enable");
        rd(4'd2, 32'h3, "R2 core2 enable");
        rd(4'd3, 32'hC, "R2 core3 enable");

        // R3: all timers high against sparse enables
        @(negedge clk); tmr_irq = 16'hFFFF;
        for (int c = 0; c < 4; c++) rd_pend(c, "R3 timer mask");
        check_irq("R10 irq timers");
        @(negedge clk); tmr_irq = 16'h1248;
        for (int c = 0; c < 4; c++) rd_pend(c, "R3 timer pattern");
        check_irq("R10 irq pattern");
        @(negedge clk); tmr_irq = '0;
        check_irq("R10 irq quiet");

        // R4/R5/R8: routing with all pmu lines high
        @(negedge clk); pmu_irq = 4'hF;
        wr(4'd4, 32'h0000_0005);
        rd(4'd4, 32'h5, "R4 set");
        wr(4'd4, 32'hFFFF_FFF6);
        rd(4'd5, 32'h7, "R4 set keeps others");
        wr(4'd5, 32'h0000_0009);
        rd(4'd4, 32'h6, "R5 clear keeps others");
        for (int c = 0; c < 4; c++) rd_pend(c, "R8 pmu routing");
        check_irq("R10 irq pmu");
        wr(4'd5, 32'h0000_0000);
        rd(4'd5, 32'h6, "R5 zero clear no effect");

        // R6 mailbox, R7 gpu
        @(negedge clk); pmu_irq = '0; mbox_irq = 16'h81E2; gpu_irq = 1'b1;
        for (int c = 0; c < 4; c++) rd_pend(c, "R6 R7 mbox gpu");
        check_irq("R10 irq mbox gpu");
        @(negedge clk); mbox_irq = '0;
        check_irq("R7 gpu core0 only");
        // R9: back-to-back pending read, same value
        rd_pend(0, "R9 read one");
        rd_pend(0, "R9 read two");
        @(negedge clk); gpu_irq = 1'b0;

        // R12: writes to pending/unmapped addresses ignored
        for (int a = 6; a < 16; a++) begin
            if (a != 6 && a != 7 && a < 8) continue;
            @(negedge clk);
            bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 32'hFFFF_FFFF;
            @(negedge clk);
            bus_wr = 1'b0;
        end
        rd(4'd0, 32'h5, "R12 enable kept");
        rd(4'd3, 32'hC, "R12 enable kept");
        rd(4'd4, 32'h6, "R12 route kept");
        rd(4'd7, 32'h0, "R11 unmapped read");
        rd(4'd14, 32'h0, "R11 unmapped read");

        // R11: rdata holds while rd low
        rd(4'd1, 32'hA, "R11 load");
        repeat (3) @(negedge clk);
        check("R11 hold", bus_rdata, 32'hA);

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule